// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences one DMA channel. A peripheral trigger, picked from a vector of trigger lines by a 5-bit code, is latched as a pending request. While the channel runs, each accepted request starts a burst of `cfg_burst_len+1` words. A transfer is `cfg_xfer_len+1` bursts. Each word is one read-strobe cycle followed by one write-strobe cycle. On the write cycle the block tells the address unit which step to apply: the in-burst step, or the between-burst step after the last word of a burst. The address arithmetic and the bus protocol live outside the block.

Software drives single-cycle command pulses: run, halt, soft reset, force or clear the trigger, force or clear the sync, and clear errors. It reads back the pending flags, the error flags and three status bits (transfer busy, burst busy, running). Options select:
- one burst per trigger, or the whole transfer from one trigger;
- stop at the end of a transfer, or reload and keep running;
- a channel interrupt at the start or at the end of each transfer.

A sync event, when enabled, is latched and then applied at the next fresh burst to the source or the destination wrap counter.

Top module: `dma_chan_seq`

## Requirements
- R1: A trigger line `trig_in[i]` can be taken only when `cfg_trig_sel` equals i and i lies in 1..29. Codes 0, 30 and 31 select nothing. A selected line raises a request only while `cfg_trig_en` is 1. `cmd_trig_set` raises a request regardless of the selection and of the enable.
- R2: `trig_pend` is 1 in the cycle after the edge that saw the request. It drops when a fresh burst takes it, and it drops on `cmd_trig_clr`.
- R3: A request that arrives while `trig_pend` is already 1, and is not being taken in that cycle, sets `ovf_flag`. `ovf_int` is a one-cycle pulse in the first cycle `ovf_flag` is 1, and only when `cfg_ovf_ie` is 1. `cmd_err_clr` clears `ovf_flag`.
- R4: Each word is one cycle of `rd_stb` followed by one cycle of `wr_stb`. A burst is `cfg_burst_len+1` words. On `wr_stb`, `step_sel` is 1 for a word that is not the last in its burst and 2 for the last word. `step_sel` is 0 at all other times.
- R5: With `cfg_oneshot` at 0, each taken request runs exactly one burst, and a transfer ends after `cfg_xfer_len+1` bursts.
- R6: With `cfg_oneshot` at 1, one taken request runs all bursts of the transfer back to back without further triggers.
- R7: At the end of a transfer with `cfg_contin` at 0, `run_sts` and `xfer_busy` fall. With `cfg_contin` at 1, the counts reload, both stay 1, and the next transfer waits for a new request.
- R8: With `cfg_int_end` at 0, `ch_int` pulses in the same cycle as the first `rd_stb` of a transfer. With `cfg_int_end` at 1, `ch_int` pulses in the cycle after the last `wr_stb` of a transfer.
- R9: `cmd_run` sets `run_sts`. When no transfer is in progress, it also loads both counts and sets `xfer_busy`. `burst_busy` is 1 from the start of a burst until its last word is written.
- R10: `cmd_halt` drops `run_sts` at the next word boundary. A started word always completes both strobes. A later `cmd_run` resumes from the same counts, so the transfer's total word count is unchanged.
- R11: In the cycle after `cmd_soft_rst`, no strobe is active and `run_sts`, `xfer_busy`, `burst_busy` and all flags are 0.
- R12: With `cfg_sync_en` at 1, `sync_in` sets `sync_pend`; `cmd_sync_set` sets it always; `cmd_sync_clr` clears it. A fresh burst start with `sync_pend` at 1 takes the sync and pulses `src_wrap_sync` when `cfg_sync_dst` is 0, or `dst_wrap_sync` when it is 1. A sync arriving while one is still pending sets `sync_err`, which `cmd_err_clr` clears.
- R13: `word_wide` equals `cfg_wide` during `rd_stb` and `wr_stb` cycles and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 32 | Peripheral trigger pulses, one line per code |
| sync_in | input | 1 | Sync event pulse |
| cfg_trig_sel | input | 5 | Trigger source code |
| cfg_trig_en | input | 1 | Peripheral trigger enable |
| cfg_ovf_ie | input | 1 | Overflow interrupt enable |
| cfg_int_end | input | 1 | Channel interrupt at end (1) or start (0) of transfer |
| cfg_oneshot | input | 1 | One trigger runs the whole transfer |
| cfg_contin | input | 1 | Reload and keep running at end of transfer |
| cfg_sync_en | input | 1 | Accept `sync_in` |
| cfg_sync_dst | input | 1 | Sync goes to the destination (1) or the source (0) wrap counter |
| cfg_wide | input | 1 | 32-bit words (1) or 16-bit words (0) |
| cfg_burst_len | input | 5 | Words per burst minus one |
| cfg_xfer_len | input | 16 | Bursts per transfer minus one |
| cmd_run | input | 1 | Run pulse |
| cmd_halt | input | 1 | Halt pulse |
| cmd_soft_rst | input | 1 | Soft reset pulse |
| cmd_trig_set | input | 1 | Force trigger pulse |
| cmd_trig_clr | input | 1 | Clear trigger pulse |
| cmd_sync_set | input | 1 | Force sync pulse |
| cmd_sync_clr | input | 1 | Clear sync pulse |
| cmd_err_clr | input | 1 | Clear overflow and sync error pulse |
| rd_stb | output | 1 | Read one word |
| wr_stb | output | 1 | Write one word |
| word_wide | output | 1 | Current word is 32 bits |
| step_sel | output | 2 | Address step: 0 none, 1 in-burst, 2 between bursts |
| src_wrap_sync | output | 1 | Resync the source wrap counter |
| dst_wrap_sync | output | 1 | Resync the destination wrap counter |
| ch_int | output | 1 | Channel interrupt pulse |
| ovf_int | output | 1 | Overflow interrupt pulse |
| trig_pend | output | 1 | Trigger request pending |
| sync_pend | output | 1 | Sync pending |
| ovf_flag | output | 1 | Trigger overflow seen |
| sync_err | output | 1 | Sync error seen |
| xfer_busy | output | 1 | Transfer in progress or pending |
| burst_busy | output | 1 | Burst in progress or pending |
| run_sts | output | 1 | Channel running |

## Verification
Timing, counted in clock edges after the stimulus:
- `trig_pend` and `sync_pend` are due one edge after their pulse.
- The first `rd_stb` of a running channel, and a start-mode `ch_int` with it, are due one edge after that.
- `wr_stb` follows each `rd_stb` by exactly one edge.
- An end-mode `ch_int` comes one edge after the last `wr_stb`.
- Soft reset clears everything by the next edge.

The bench drives inputs on falling edges and samples on the next falling edge, so each check lands on the cycle in which its result is due. The per-cycle checks cover the trigger latch, the first strobes and the interrupt cycle. A falling-edge monitor counts strobes, steps and pulses, and the bench compares those totals after a wait long enough for the whole burst or transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      SQ_WAIT = 2'd0,
      SQ_RD   = 2'd1,
      SQ_WR   = 2'd2
   } seq_state_t;

   typedef enum logic [1:0] {
      STEP_NONE  = 2'd0,
      STEP_BURST = 2'd1,
      STEP_XFER  = 2'd2
   } step_t;

   // True when a selector code names a real trigger line
   function automatic logic code_in_range(input int code, input int lo, input int hi);
      return (code >= lo) && (code <= hi);
   endfunction

endpackage

// File: rtl/dma_trig_mux.sv
module dma_trig_mux
   import dma_seq_pkg::*;
#(
   parameter int SEL_W     = 5,
   parameter int CODE_LO   = 1,
   parameter int CODE_HI   = 29
) (
   input  logic [(1<<SEL_W)-1:0] trig_in,
   input  logic [SEL_W-1:0]      sel,
   input  logic                  enable,
   output logic                  hit
);
   localparam int LINES = 1 << SEL_W;

   logic [LINES-1:0] match;

   // One compare per line; codes outside the range never match
   for (genvar gi = 0; gi < LINES; gi++) begin : g_line
      if (code_in_range(gi, CODE_LO, CODE_HI)) begin : g_live
         assign match[gi] = trig_in[gi] && (sel == SEL_W'(gi));
      end else begin : g_dead
         assign match[gi] = 1'b0;
      end
   end

   assign hit = enable && (|match);

endmodule

// File: rtl/dma_evt_latch.sv
module dma_evt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   input  logic evt,
   input  logic force_set,
   input  logic clr,
   input  logic consume,
   input  logic err_clr,
   output logic pend,
   output logic err
);
   logic arrive;
   logic collide;

   assign arrive  = evt | force_set;
   assign collide = arrive && pend && !consume;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         err  <= 1'b0;
      end else if (srst) begin
         pend <= 1'b0;
         err  <= 1'b0;
      end else begin
         if (clr)          pend <= 1'b0;
         else if (arrive)  pend <= 1'b1;
         else if (consume) pend <= 1'b0;

         if (err_clr)      err <= 1'b0;
         else if (collide) err <= 1'b1;
      end
   end

endmodule

// File: rtl/dma_seq_ctl.sv
module dma_seq_ctl
   import dma_seq_pkg::*;
#(
   parameter int BL_W = 5,
   parameter int TL_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            halt,
   input  logic            srst,
   input  logic            trig_pend,
   input  logic            sync_pend,
   input  logic            cfg_oneshot,
   input  logic            cfg_contin,
   input  logic            cfg_int_end,
   input  logic            cfg_sync_dst,
   input  logic [BL_W-1:0] burst_len,
   input  logic [TL_W-1:0] xfer_len,
   output logic            rd_stb,
   output logic            wr_stb,
   output logic [1:0]      step_sel,
   output logic            trig_take,
   output logic            sync_take,
   output logic            ch_int,
   output logic            src_wrap_sync,
   output logic            dst_wrap_sync,
   output logic            run_sts,
   output logic            xfer_busy,
   output logic            burst_busy
);
   seq_state_t      state;
   logic [BL_W-1:0] wcnt;
   logic [TL_W-1:0] bcnt;
   logic            os_go;
   logic            first_burst;
   logic            halt_pend;

   logic waiting, start_fresh, resume, halt_now, last_word, last_burst;

   assign waiting     = (state == SQ_WAIT) && run_sts && !halt && !srst;
   assign start_fresh = waiting && !burst_busy && (os_go || trig_pend);
   assign resume      = waiting && burst_busy;
   assign trig_take   = start_fresh && !os_go;
   assign sync_take   = start_fresh && sync_pend;
   assign halt_now    = halt || halt_pend;
   assign last_word   = (wcnt == '0);
   assign last_burst  = (bcnt == '0);

   assign rd_stb   = (state == SQ_RD);
   assign wr_stb   = (state == SQ_WR);
   assign step_sel = (state != SQ_WR) ? STEP_NONE :
                     (last_word ? STEP_XFER : STEP_BURST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= SQ_WAIT;
         wcnt          <= '0;
         bcnt          <= '0;
         os_go         <= 1'b0;
         first_burst   <= 1'b0;
         halt_pend     <= 1'b0;
         run_sts       <= 1'b0;
         xfer_busy     <= 1'b0;
         burst_busy    <= 1'b0;
         ch_int        <= 1'b0;
         src_wrap_sync <= 1'b0;
         dst_wrap_sync <= 1'b0;
      end else begin
         ch_int        <= 1'b0;
         src_wrap_sync <= 1'b0;
         dst_wrap_sync <= 1'b0;
         if (srst) begin
            state       <= SQ_WAIT;
            wcnt        <= '0;
            bcnt        <= '0;
            os_go       <= 1'b0;
            first_burst <= 1'b0;
            halt_pend   <= 1'b0;
            run_sts     <= 1'b0;
            xfer_busy   <= 1'b0;
            burst_busy  <= 1'b0;
         end else begin
            if (run) begin
               run_sts   <= 1'b1;
               halt_pend <= 1'b0;
               if (!xfer_busy) begin
                  bcnt        <= xfer_len;
                  xfer_busy   <= 1'b1;
                  first_burst <= 1'b1;
                  os_go       <= 1'b0;
               end
            end
            unique case (state)
               SQ_WAIT: begin
                  if (halt) begin
                     run_sts <= 1'b0;
                  end else if (start_fresh) begin
                     state      <= SQ_RD;
                     wcnt       <= burst_len;
                     burst_busy <= 1'b1;
                     if (trig_take && cfg_oneshot) os_go <= 1'b1;
                     if (first_burst) begin
                        first_burst <= 1'b0;
                        ch_int      <= !cfg_int_end;
                     end
                     if (sync_take) begin
                        src_wrap_sync <= !cfg_sync_dst;
                        dst_wrap_sync <= cfg_sync_dst;
                     end
                  end else if (resume) begin
                     state <= SQ_RD;
                  end
               end
               SQ_RD: begin
                  if (halt) halt_pend <= 1'b1;
                  state <= SQ_WR;
               end
               SQ_WR: begin
                  halt_pend <= 1'b0;
                  if (!last_word) begin
                     wcnt <= wcnt - 1'b1;
                     if (halt_now) begin
                        state   <= SQ_WAIT;
                        run_sts <= 1'b0;
                     end else begin
                        state <= SQ_RD;
                     end
                  end else begin
                     state      <= SQ_WAIT;
                     burst_busy <= 1'b0;
                     if (!last_burst) begin
                        bcnt <= bcnt - 1'b1;
                        if (halt_now) run_sts <= 1'b0;
                     end else begin
                        os_go <= 1'b0;
                        if (cfg_int_end) ch_int <= 1'b1;
                        if (cfg_contin) begin
                           bcnt        <= xfer_len;
                           first_burst <= 1'b1;
                           if (halt_now) run_sts <= 1'b0;
                        end else begin
                           run_sts   <= 1'b0;
                           xfer_busy <= 1'b0;
                        end
                     end
                  end
               end
               default: state <= SQ_WAIT;
            endcase
         end
      end
   end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int SEL_W   = 5,
   parameter int CODE_LO = 1,
   parameter int CODE_HI = 29,
   parameter int BL_W    = 5,
   parameter int TL_W    = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [(1<<SEL_W)-1:0] trig_in,
   input  logic                  sync_in,
   input  logic [SEL_W-1:0]      cfg_trig_sel,
   input  logic                  cfg_trig_en,
   input  logic                  cfg_ovf_ie,
   input  logic                  cfg_int_end,
   input  logic                  cfg_oneshot,
   input  logic                  cfg_contin,
   input  logic                  cfg_sync_en,
   input  logic                  cfg_sync_dst,
   input  logic                  cfg_wide,
   input  logic [BL_W-1:0]       cfg_burst_len,
   input  logic [TL_W-1:0]       cfg_xfer_len,
   input  logic                  cmd_run,
   input  logic                  cmd_halt,
   input  logic                  cmd_soft_rst,
   input  logic                  cmd_trig_set,
   input  logic                  cmd_trig_clr,
   input  logic                  cmd_sync_set,
   input  logic                  cmd_sync_clr,
   input  logic                  cmd_err_clr,
   output logic                  rd_stb,
   output logic                  wr_stb,
   output logic                  word_wide,
   output logic [1:0]            step_sel,
   output logic                  src_wrap_sync,
   output logic                  dst_wrap_sync,
   output logic                  ch_int,
   output logic                  ovf_int,
   output logic                  trig_pend,
   output logic                  sync_pend,
   output logic                  ovf_flag,
   output logic                  sync_err,
   output logic                  xfer_busy,
   output logic                  burst_busy,
   output logic                  run_sts
);
   localparam int LINES = 1 << SEL_W;

   // Elaboration-time parameter checks
   if (SEL_W < 2 || SEL_W > 8) begin : g_bad_sel
      $error("dma_chan_seq: SEL_W must be 2..8");
   end
   if (CODE_LO < 1 || CODE_HI >= LINES || CODE_LO > CODE_HI) begin : g_bad_codes
      $error("dma_chan_seq: trigger code range invalid");
   end
   if (BL_W < 1 || BL_W > 16) begin : g_bad_bl
      $error("dma_chan_seq: BL_W must be 1..16");
   end
   if (TL_W < 1 || TL_W > 32) begin : g_bad_tl
      $error("dma_chan_seq: TL_W must be 1..32");
   end

   logic trig_hit, trig_take, sync_take;
   logic ovf_seen_q;

   dma_trig_mux #(
      .SEL_W   (SEL_W),
      .CODE_LO (CODE_LO),
      .CODE_HI (CODE_HI)
   ) u_mux (
      .trig_in (trig_in),
      .sel     (cfg_trig_sel),
      .enable  (cfg_trig_en),
      .hit     (trig_hit)
   );

   dma_evt_latch u_trig_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (cmd_soft_rst),
      .evt       (trig_hit),
      .force_set (cmd_trig_set),
      .clr       (cmd_trig_clr),
      .consume   (trig_take),
      .err_clr   (cmd_err_clr),
      .pend      (trig_pend),
      .err       (ovf_flag)
   );

   dma_evt_latch u_sync_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (cmd_soft_rst),
      .evt       (sync_in && cfg_sync_en),
      .force_set (cmd_sync_set),
      .clr       (cmd_sync_clr),
      .consume   (sync_take),
      .err_clr   (cmd_err_clr),
      .pend      (sync_pend),
      .err       (sync_err)
   );

   dma_seq_ctl #(
      .BL_W (BL_W),
      .TL_W (TL_W)
   ) u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .run           (cmd_run),
      .halt          (cmd_halt),
      .srst          (cmd_soft_rst),
      .trig_pend     (trig_pend),
      .sync_pend     (sync_pend),
      .cfg_oneshot   (cfg_oneshot),
      .cfg_contin    (cfg_contin),
      .cfg_int_end   (cfg_int_end),
      .cfg_sync_dst  (cfg_sync_dst),
      .burst_len     (cfg_burst_len),
      .xfer_len      (cfg_xfer_len),
      .rd_stb        (rd_stb),
      .wr_stb        (wr_stb),
      .step_sel      (step_sel),
      .trig_take     (trig_take),
      .sync_take     (sync_take),
      .ch_int        (ch_int),
      .src_wrap_sync (src_wrap_sync),
      .dst_wrap_sync (dst_wrap_sync),
      .run_sts       (run_sts),
      .xfer_busy     (xfer_busy),
      .burst_busy    (burst_busy)
   );

   // Overflow interrupt: first cycle the overflow flag is seen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_seen_q <= 1'b0;
      else        ovf_seen_q <= ovf_flag;
   end

   assign ovf_int   = cfg_ovf_ie && ovf_flag && !ovf_seen_q;
   assign word_wide = cfg_wide && (rd_stb || wr_stb);

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_soft_rst,
   input logic       cfg_ovf_ie,
   input logic       rd_stb,
   input logic       wr_stb,
   input logic [1:0] step_sel,
   input logic       src_wrap_sync,
   input logic       dst_wrap_sync,
   input logic       ovf_int,
   input logic       trig_pend,
   input logic       ovf_flag,
   input logic       xfer_busy,
   input logic       burst_busy,
   input logic       run_sts
);
   // R4
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && !cmd_soft_rst |=> wr_stb);

   // R4
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(rd_stb));

   // R4
   step_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_sel != 2'd0) |-> wr_stb);

   // R11
   soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_soft_rst |=> !rd_stb && !wr_stb && !run_sts && !xfer_busy && !burst_busy);

   // R3
   ovf_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(trig_pend));

   // R3
   ovf_int_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_int |-> cfg_ovf_ie ##1 !ovf_int);

   // R10
   halt_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_sts) |-> !rd_stb && !wr_stb);

   // R12
   one_wrap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({src_wrap_sync, dst_wrap_sync}));

endmodule

bind dma_chan_seq dma_chan_seq_chk u_chk (.*);

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] trig_in = '0;
   logic        sync_in = 1'b0;
   logic [4:0]  cfg_trig_sel = 5'd5;
   logic        cfg_trig_en = 1'b1, cfg_ovf_ie = 1'b0, cfg_int_end = 1'b0;
   logic        cfg_oneshot = 1'b0, cfg_contin = 1'b0, cfg_sync_en = 1'b0;
   logic        cfg_sync_dst = 1'b0, cfg_wide = 1'b0;
   logic [4:0]  cfg_burst_len = '0;
   logic [15:0] cfg_xfer_len = '0;
   logic        cmd_run = 0, cmd_halt = 0, cmd_soft_rst = 0, cmd_trig_set = 0;
   logic        cmd_trig_clr = 0, cmd_sync_set = 0, cmd_sync_clr = 0, cmd_err_clr = 0;
   logic        rd_stb, wr_stb, word_wide, src_wrap_sync, dst_wrap_sync;
   logic        ch_int, ovf_int, trig_pend, sync_pend, ovf_flag, sync_err;
   logic        xfer_busy, burst_busy, run_sts;
   logic [1:0]  step_sel;

   dma_chan_seq u_dma_chan_seq (.*);

   always #2 clk = ~clk;

   int checks = 0, fails = 0;
   int cyc = 0, n_rd = 0, n_wr = 0, n_sb = 0, n_sx = 0, n_int = 0, n_ovi = 0;
   int n_src = 0, n_dst = 0, n_wide = 0, last_wr_cyc = 0, int_cyc = 0;
   bit done = 0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (rd_stb) n_rd <= n_rd + 1;
         if (wr_stb) begin n_wr <= n_wr + 1; last_wr_cyc <= cyc; end
         if (step_sel == 2'd1) n_sb <= n_sb + 1;
         if (step_sel == 2'd2) n_sx <= n_sx + 1;
         if (ch_int) begin n_int <= n_int + 1; int_cyc <= cyc; end
         if (ovf_int) n_ovi <= n_ovi + 1;
         if (src_wrap_sync) n_src <= n_src + 1;
         if (dst_wrap_sync) n_dst <= n_dst + 1;
         if (word_wide) n_wide <= n_wide + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic eq(input string req, input int act, input int exp);
      check(act == exp, req, act, exp);
   endtask

   task automatic clr_counts();
      n_rd = 0; n_wr = 0; n_sb = 0; n_sx = 0; n_int = 0; n_ovi = 0;
      n_src = 0; n_dst = 0; n_wide = 0;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // 0 run,1 halt,2 soft reset,3 trig set,4 trig clr,5 sync set,6 sync clr,7 err clr
   task automatic cmd(input int which);
      case (which)
         0: cmd_run = 1;      1: cmd_halt = 1;     2: cmd_soft_rst = 1;
         3: cmd_trig_set = 1; 4: cmd_trig_clr = 1; 5: cmd_sync_set = 1;
         6: cmd_sync_clr = 1; default: cmd_err_clr = 1;
      endcase
      @(negedge clk);
      {cmd_run, cmd_halt, cmd_soft_rst, cmd_trig_set} = '0;
      {cmd_trig_clr, cmd_sync_set, cmd_sync_clr, cmd_err_clr} = '0;
   endtask

   task automatic pulse_trig(input logic [31:0] lines);
      trig_in = lines;
      @(negedge clk);
      trig_in = '0;
   endtask

   task automatic pulse_sync();
      sync_in = 1;
      @(negedge clk);
      sync_in = 0;
   endtask

   function automatic int burst_cycles(input int b);
      return 2 * (b + 1) + 1;
   endfunction

   initial begin : watchdog
      wait_cyc(150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int b, t, words, base;
      void'($urandom(32'd2024));
      wait_cyc(3);
      rst_n = 1;
      @(negedge clk);
      eq("R11 reset strobes", int'(rd_stb | wr_stb), 0);
      eq("R9 reset status", int'({run_sts, xfer_busy, burst_busy, trig_pend, ovf_flag}), 0);

      // R1: dead codes and enable
      cfg_trig_sel = 5'd0;  pulse_trig('1);
      eq("R1 code 0 ignored", trig_pend, 0);
      cfg_trig_sel = 5'd30; pulse_trig('1);
      eq("R1 code 30 ignored", trig_pend, 0);
      cfg_trig_sel = 5'd29; pulse_trig(32'h2000_0000);
      eq("R1 code 29 accepted", trig_pend, 1);
      cmd(4);
      eq("R2 clear command", trig_pend, 0);
      cfg_trig_sel = 5'd5; cfg_trig_en = 0; pulse_trig(32'h20);
      eq("R1 enable off ignored", trig_pend, 0);
      cmd(3);
      eq("R1 force sets", trig_pend, 1);
      cfg_trig_en = 1;

      // R3: overflow with interrupt enabled, then disabled
      cfg_ovf_ie = 1; clr_counts();
      pulse_trig(32'h20);
      @(negedge clk);
      eq("R3 overflow flag", ovf_flag, 1);
      eq("R3 overflow interrupt", n_ovi, 1);
      cmd(7);
      eq("R3 error clear", ovf_flag, 0);
      cfg_ovf_ie = 0; pulse_trig(32'h20); wait_cyc(2);
      eq("R3 flag without enable", ovf_flag, 1);
      eq("R3 no interrupt when disabled", n_ovi, 1);
      cmd(7); cmd(4);

      // R4 R5 R8 R9 R13: one burst per trigger, start interrupt
      b = $urandom_range(0, 6); t = 2;
      cfg_burst_len = 5'(b); cfg_xfer_len = 16'(t); cfg_wide = 1'($urandom_range(0, 1));
      cmd(0);
      eq("R9 run sets status", int'({run_sts, xfer_busy, burst_busy}), 3'b110);
      clr_counts();
      pulse_trig(32'h20);
      eq("R2 pending one cycle after", trig_pend, 1);
      eq("R4 no read yet", rd_stb, 0);
      @(negedge clk);
      eq("R4 first read", rd_stb, 1);
      eq("R8 start interrupt with first read", ch_int, 1);
      eq("R2 pending taken", trig_pend, 0);
      eq("R9 burst busy", burst_busy, 1);
      eq("R13 wide during read", word_wide, cfg_wide);
      @(negedge clk);
      eq("R4 write follows read", wr_stb, 1);
      wait_cyc(burst_cycles(b) + 3);
      eq("R5 one burst per trigger", n_rd, b + 1);
      eq("R5 transfer still busy", xfer_busy, 1);
      for (int k = 1; k <= t; k++) begin
         pulse_trig(32'h20);
         wait_cyc(burst_cycles(b) + 3);
      end
      eq("R5 total reads", n_rd, (t + 1) * (b + 1));
      eq("R4 write count", n_wr, (t + 1) * (b + 1));
      eq("R4 in-burst steps", n_sb, (t + 1) * b);
      eq("R4 end-of-burst steps", n_sx, t + 1);
      eq("R8 one start interrupt", n_int, 1);
      eq("R7 stopped at end", int'({run_sts, xfer_busy}), 0);
      eq("R13 wide count", n_wide, cfg_wide ? 2 * (t + 1) * (b + 1) : 0);

      // R6 R8 R13: one-shot, end interrupt
      b = $urandom_range(0, 4); t = $urandom_range(1, 3);
      cfg_burst_len = 5'(b); cfg_xfer_len = 16'(t);
      cfg_oneshot = 1; cfg_int_end = 1; cfg_wide = 1;
      cmd(0); clr_counts();
      pulse_trig(32'h20);
      wait_cyc((t + 1) * burst_cycles(b) + 8);
      eq("R6 all bursts from one trigger", n_rd, (t + 1) * (b + 1));
      eq("R6 bursts", n_sx, t + 1);
      eq("R8 one end interrupt", n_int, 1);
      eq("R8 end interrupt after last write", int_cyc, last_wr_cyc + 1);
      eq("R7 stopped", run_sts, 0);
      eq("R13 wide every strobe", n_wide, n_rd + n_wr);

      // R7: continuous one-shot
      cfg_contin = 1; cfg_int_end = 0;
      cmd(0); clr_counts();
      words = (t + 1) * (b + 1);
      pulse_trig(32'h20);
      wait_cyc((t + 1) * burst_cycles(b) + 8);
      eq("R7 continuous first transfer", n_rd, words);
      eq("R7 continuous keeps running", int'({run_sts, xfer_busy}), 3);
      wait_cyc(10);
      eq("R7 waits for new trigger", n_rd, words);
      pulse_trig(32'h20);
      wait_cyc((t + 1) * burst_cycles(b) + 8);
      eq("R7 second transfer", n_rd, 2 * words);
      eq("R8 interrupt per transfer", n_int, 2);
      cmd(2); cfg_contin = 0;

      // R10: halt mid-burst, resume
      cfg_burst_len = 5'd15; cfg_xfer_len = 16'd1;
      cmd(0); clr_counts();
      pulse_trig(32'h20);
      wait_cyc(5);
      cmd(1);
      wait_cyc(4);
      eq("R10 halted", run_sts, 0);
      eq("R10 word completed", n_wr, n_rd);
      eq("R10 burst still pending", burst_busy, 1);
      base = n_rd;
      wait_cyc(10);
      eq("R10 no strobes while halted", n_rd, base);
      check(base < 32, "R10 stopped early", base, 31);
      cmd(0);
      wait_cyc(2 * burst_cycles(15) + 8);
      eq("R10 resumed total", n_rd, 32);
      eq("R10 finished", run_sts, 0);

      // R11: soft reset mid-transfer
      cfg_xfer_len = 16'd3;
      cmd(0); clr_counts();
      pulse_trig(32'h20);
      wait_cyc(7);
      cmd(2);
      eq("R11 idle next cycle", int'({rd_stb, wr_stb, run_sts, xfer_busy, burst_busy}), 0);
      base = n_rd;
      wait_cyc(10);
      eq("R11 no further strobes", n_rd, base);

      // R12: sync
      cfg_oneshot = 0; cfg_burst_len = 5'd1; cfg_xfer_len = 16'd0;
      cfg_sync_en = 1; cfg_sync_dst = 0; clr_counts();
      pulse_sync();
      eq("R12 sync latched", sync_pend, 1);
      cmd(0); pulse_trig(32'h20); wait_cyc(8);
      eq("R12 source wrap sync", n_src, 1);
      eq("R12 no destination sync", n_dst, 0);
      eq("R12 sync taken", sync_pend, 0);
      cfg_sync_dst = 1;
      pulse_sync(); pulse_sync();
      eq("R12 sync error", sync_err, 1);
      cmd(7);
      eq("R12 error cleared", sync_err, 0);
      cmd(6);
      eq("R12 sync cleared", sync_pend, 0);
      cfg_sync_en = 0; pulse_sync();
      eq("R12 disabled sync ignored", sync_pend, 0);
      cmd(5);
      cmd(0); pulse_trig(32'h20); wait_cyc(8);
      eq("R12 destination wrap sync", n_dst, 1);
      eq("R12 source count unchanged", n_src, 1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule